// File: doc/BRIEF.md
# Four-Bit-Coded 32-bit ALU

A purely combinational arithmetic logic unit for a 32-bit integer datapath. A 4-bit operation code selects one of six functions on two operands: bitwise AND, bitwise OR, bitwise NOR, addition, subtraction and a signed set-if-less comparison. Alongside the 32-bit result it reports a zero flag, a signed overflow flag and the adder's carry-out.

The operation code is not decoded through a table. Its top bit inverts operand A and its next bit inverts operand B. That same B-invert bit also serves as the adder's carry-in. The two low bits choose the output source: AND gate, OR gate, adder sum or comparison bit. So subtraction is A plus inverted B plus one, and NOR is inverted A ANDed with inverted B. A single adder serves add, subtract and compare. A parameter chooses between a bit-serial ripple carry chain and a whole-word adder. Both give identical outputs. The block has no state and no clock, and it is meant to sit between operand and writeback stages of an integer pipeline.

Top module: `quad_op_alu`

## Requirements
- R1: Code 4'b0000 gives result = a AND b.
- R2: Code 4'b0001 gives result = a OR b.
- R3: Code 4'b1100 gives result = NOT (a OR b).
- R4: Code 4'b0010 gives result = (a + b) mod 2^32, and carry_out is bit 32 of the unsigned 33-bit sum.
- R5: Code 4'b0110 gives result = (a - b) mod 2^32, and carry_out is 1 exactly when a >= b as unsigned numbers (no borrow).
- R6: For codes 4'b0010 and 4'b0110, overflow is 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R7: Code 4'b0111 gives result = 1 when a < b as signed 32-bit numbers and 0 otherwise, with bits 31..1 always 0. The answer stays correct when a - b overflows.
- R8: zero is 1 exactly when all 32 result bits are 0, for every code.
- R9: For codes 4'b0000, 4'b0001, 4'b1100 and 4'b0111, overflow and carry_out are both 0.
- R10: The ripple variant (LOOKAHEAD = 0) and the whole-word variant (LOOKAHEAD = 1) give identical result, zero, overflow and carry_out for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code: bit 3 inverts A, bit 2 inverts B and sets carry-in, bits 1..0 pick the output source |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Function output |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry from the top adder bit on add or subtract |

## Verification
The assertions check four things whenever the inputs change. The ripple chain must agree with a whole-word sum. AND and NOR must match the operand gates. The comparison's upper bits must be clear. The flags must stay low on logical and compare codes, and an add overflow must always show the sign pattern of a true overflow. The bench's scenarios cover what a property cannot show. Overflow must fire in every overflowing case, not only be consistent when it fires. The comparison must be correct across the 0x7FFFFFFF / 0x80000000 boundary, where the subtraction wraps. Both adder variants must give the same values under random operands.

// File: rtl/qalu_pkg.sv
package qalu_pkg;
   // source select carried in the two low bits of the operation code
   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } qalu_sel_e;

   localparam logic [3:0] OPC_AND  = 4'b0000;
   localparam logic [3:0] OPC_OR   = 4'b0001;
   localparam logic [3:0] OPC_ADD  = 4'b0010;
   localparam logic [3:0] OPC_SUB  = 4'b0110;
   localparam logic [3:0] OPC_LESS = 4'b0111;
   localparam logic [3:0] OPC_NOR  = 4'b1100;
endpackage

// File: rtl/qalu_prep.sv
module qalu_prep #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         inv_a,
   input  logic         inv_b,
   output logic [W-1:0] a_x,
   output logic [W-1:0] b_x
);
   // conditional inversion: XOR with a replicated control bit
   assign a_x = a ^ {W{inv_a}};
   assign b_x = b ^ {W{inv_b}};
endmodule

// File: rtl/qalu_adder.sv
module qalu_adder #(
   parameter int W         = 32,
   parameter bit LOOKAHEAD = 1'b0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         c_into_msb,
   output logic         c_out
);
   localparam int MSB = W - 1;

   generate
      if (LOOKAHEAD) begin : g_word
         logic [W:0] full;
         assign full       = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
         assign sum        = full[MSB:0];
         assign c_out      = full[W];
         // carry into top bit recovered from the top bit's sum equation
         assign c_into_msb = full[MSB] ^ x[MSB] ^ y[MSB];
      end else begin : g_ripple
         logic [W:0] chain;
         always_comb begin
            chain[0] = cin;
            for (int i = 0; i < W; i++) begin
               sum[i]       = x[i] ^ y[i] ^ chain[i];
               chain[i + 1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
            end
         end
         assign c_out      = chain[W];
         assign c_into_msb = chain[MSB];

         // R10
         always_comb begin
            ripple_sum_chk: assert ({c_out, sum} ==
               ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}));
         end
      end
   endgenerate
endmodule

// File: rtl/qalu_select.sv
module qalu_select
   import qalu_pkg::*;
#(
   parameter int W = 32
) (
   input  qalu_sel_e    sel,
   input  logic [W-1:0] a_x,
   input  logic [W-1:0] b_x,
   input  logic [W-1:0] sum,
   input  logic         c_into_msb,
   input  logic         c_out,
   output logic [W-1:0] result,
   output logic         zero,
   output logic         overflow,
   output logic         carry_out
);
   localparam int MSB = W - 1;

   logic ovf_raw;
   logic less;
   logic arith;

   always_comb begin
      ovf_raw = c_into_msb ^ c_out;
      // sign of the difference corrected by overflow
      less    = sum[MSB] ^ ovf_raw;
      arith   = (sel == SEL_SUM);
      unique case (sel)
         SEL_AND:  result = a_x & b_x;
         SEL_OR:   result = a_x | b_x;
         SEL_SUM:  result = sum;
         default:  result = {{(W-1){1'b0}}, less};
      endcase
      overflow  = arith & ovf_raw;
      carry_out = arith & c_out;
      zero      = ~|result;
   end
endmodule

// File: rtl/quad_op_alu.sv
module quad_op_alu
   import qalu_pkg::*;
#(
   parameter int W         = 32,
   parameter bit LOOKAHEAD = 1'b0
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] result,
   output logic         zero,
   output logic         overflow,
   output logic         carry_out
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("quad_op_alu: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] a_x;
   logic [W-1:0] b_x;
   logic [W-1:0] sum;
   logic         c_into_msb;
   logic         c_out;
   qalu_sel_e    sel;

   assign sel = qalu_sel_e'(op[1:0]);

   qalu_prep #(.W(W)) u_prep (
      .a(a), .b(b), .inv_a(op[3]), .inv_b(op[2]),
      .a_x(a_x), .b_x(b_x)
   );

   // B-invert bit doubles as the adder carry-in
   qalu_adder #(.W(W), .LOOKAHEAD(LOOKAHEAD)) u_add (
      .x(a_x), .y(b_x), .cin(op[2]),
      .sum(sum), .c_into_msb(c_into_msb), .c_out(c_out)
   );

   qalu_select #(.W(W)) u_sel (
      .sel(sel), .a_x(a_x), .b_x(b_x), .sum(sum),
      .c_into_msb(c_into_msb), .c_out(c_out),
      .result(result), .zero(zero),
      .overflow(overflow), .carry_out(carry_out)
   );

   always_comb begin
      // R1
      if (op == OPC_AND) and_path_chk: assert (result == (a & b));
      // R3
      if (op == OPC_NOR) nor_path_chk: assert (result == ~(a | b));
      // R7
      if (op == OPC_LESS) less_upper_chk: assert (result[MSB:1] == '0);
      // R9
      if (op == OPC_AND || op == OPC_OR || op == OPC_NOR || op == OPC_LESS)
         flags_idle_chk: assert (!overflow && !carry_out);
      // R6
      if (op == OPC_ADD && overflow)
         add_ovf_sign_chk: assert (a[MSB] == b[MSB] && result[MSB] != a[MSB]);
   end
endmodule

// File: tb/quad_op_alu_test.sv
module quad_op_alu_test;
   logic        clk = 1'b0;
   logic [3:0]  op = 4'b0000;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic [31:0] r0, r1;
   logic        z0, z1, v0, v1, c0, c1;
   int          n_chk = 0;
   int          n_bad = 0;
   int          cycles = 0;

   always #5 clk = ~clk;

   quad_op_alu #(.W(32), .LOOKAHEAD(1'b0)) uut (
      .op(op), .a(a), .b(b), .result(r0), .zero(z0), .overflow(v0), .carry_out(c0));
   quad_op_alu #(.W(32), .LOOKAHEAD(1'b1)) uut_cla (
      .op(op), .a(a), .b(b), .result(r1), .zero(z1), .overflow(v1), .carry_out(c1));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, got, exp);
      end
   endtask

   // apply at a falling edge, sample mid-low phase; compare both variants to the model
   task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [32:0] s;
      logic [31:0] er;
      logic        ev, ec;
      @(negedge clk);
      op = o; a = x; b = y;
      #2;
      ev = 1'b0; ec = 1'b0; er = '0;
      case (o)
         4'b0000: er = x & y;
         4'b0001: er = x | y;
         4'b1100: er = ~(x | y);
         4'b0010: begin
            s = {1'b0, x} + {1'b0, y}; er = s[31:0]; ec = s[32];
            ev = (x[31] == y[31]) && (er[31] != x[31]);
         end
         4'b0110: begin
            er = x - y; ec = (x >= y);
            ev = (x[31] != y[31]) && (er[31] != x[31]);
         end
         4'b0111: er = {31'b0, ($signed(x) < $signed(y))};
         default: er = 'x;
      endcase
      check({tag, " result"}, r0, er);
      check({tag, " zero R8"}, {31'b0, z0}, {31'b0, (er == 0)});
      check({tag, " overflow R6/R9"}, {31'b0, v0}, {31'b0, ev});
      check({tag, " carry R4/R5/R9"}, {31'b0, c0}, {31'b0, ec});
      check({tag, " R10 variant"}, r1, r0);
      check({tag, " R10 flags"}, {29'b0, z1, v1, c1}, {29'b0, z0, v0, c0});
   endtask

   task automatic t_reset_state;
      @(negedge clk); #2;
      check("R1 idle result", r0, 32'h0);
      check("R8 idle zero", {31'b0, z0}, 32'h1);
   endtask

   task automatic t_logic;
      run("R1 and", 4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF);
      run("R1 and", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
      run("R2 or",  4'b0001, 32'hAAAA_0000, 32'h0000_5555);
      run("R2 or",  4'b0001, 32'h0, 32'h0);
      run("R3 nor", 4'b1100, 32'hFFFF_0000, 32'h00FF_00FF);
      run("R3 nor", 4'b1100, 32'h0, 32'h0);
      run("R3 nor", 4'b1100, 32'hFFFF_FFFF, 32'h0);
   endtask

   task automatic t_add;
      run("R4 add", 4'b0010, 32'd5, 32'd7);
      run("R4 add", 4'b0010, 32'hFFFF_FFFF, 32'd1);
      run("R6 add", 4'b0010, 32'h7FFF_FFFF, 32'd1);
      run("R6 add", 4'b0010, 32'h8000_0000, 32'h8000_0000);
      run("R6 add", 4'b0010, 32'h8000_0000, 32'hFFFF_FFFF);
   endtask

   task automatic t_sub;
      run("R5 sub", 4'b0110, 32'd9, 32'd9);
      run("R5 sub", 4'b0110, 32'd3, 32'd10);
      run("R6 sub", 4'b0110, 32'h8000_0000, 32'd1);
      run("R6 sub", 4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run("R5 sub", 4'b0110, 32'h0, 32'h8000_0000);
   endtask

   task automatic t_less;
      run("R7 slt", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
      run("R7 slt", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
      run("R7 slt", 4'b0111, 32'hFFFF_FFFF, 32'd0);
      run("R7 slt", 4'b0111, 32'd4, 32'd4);
      run("R7 slt", 4'b0111, 32'd2, 32'd3);
   endtask

   task automatic t_random;
      logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
      for (int i = 0; i < 300; i++) begin
         logic [31:0] x, y;
         x = $urandom; y = (i % 7 == 0) ? x : $urandom;
         run("R10 random", codes[i % 6], x, y);
      end
   endtask

   initial begin
      t_reset_state();
      t_logic();
      t_add();
      t_sub();
      t_less();
      t_random();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule